// File: doc/BRIEF.md
# Programming Mode Entry Sequencer

This block sits on the programmer side of a serial in-circuit programming link. It drives three target pins: an active-low reset line, a serial programming clock and a serial programming data line. A single-cycle start request makes it produce the whole entry waveform. The reset line is held low with clock and data low. A short reset pulse follows. Then a 32-bit key is shifted out, the reset line is released, the block waits for the target to settle, and two 34-clock setup frames are sent. After that the block parks with reset released and raises a ready flag.

While ready, a single-cycle exit request ends the session. The reset line goes low and is held there for at least one millisecond, and then the block returns to idle. All delays are counted in system clocks and derived from a clock-frequency parameter. A second parameter sets the half period of the programming clock. Data changes only while the programming clock is low, so each bit is stable at the next rising edge.

Top module: `prog_entry_seq`

## Requirements
- R1: Out of system reset, and whenever idle, the target reset, programming clock and programming data outputs are all 0, and busy and ready are 0.
- R2: After start is accepted, target reset, clock and data stay 0 for at least CLK_HZ/1000 system clocks before the reset pulse.
- R3: The reset pulse is high for exactly ceil(CLK_HZ x 20 ns) system clocks (at least 1), which must not exceed 2 µs.
- R4: The key 0x8A12C2B2 is sent least significant bit first, one bit per programming clock, and each bit is valid at the rising clock edge. The data line never changes while the clock is high.
- R5: Target reset rises only after the falling edge of the 32nd programming clock, with the clock low and exactly 32 clocks issued so far.
- R6: After reset rises, the programming clock stays low for at least CLK_HZ/2000 system clocks before the next rising edge.
- R7: Two frames follow. Each frame is two 0 bits and then 0x00801000, least significant bit first. The whole entry uses exactly 100 programming clocks.
- R8: When the entry completes, ready is 1, busy is 0, target reset stays 1 and the clock stays low.
- R9: A start request is ignored unless the block is idle. This applies both during a sequence and while ready.
- R10: An exit request while ready drives target reset, clock and data to 0. Busy is then held 1 for at least CLK_HZ/1000 system clocks, after which the block is idle.
- R11: An exit request is ignored unless the block is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | System reset, active low |
| start_i | input | 1 | Single-cycle request to run the entry waveform |
| exit_i | input | 1 | Single-cycle request to end the session |
| tgt_rst_no | output | 1 | Target reset line, active low |
| pgm_clk_o | output | 1 | Serial programming clock |
| pgm_dat_o | output | 1 | Serial programming data |
| busy_o | output | 1 | A sequence or exit hold is in progress |
| ready_o | output | 1 | Entry complete, session active |

## Verification
A scoreboard queues the 100 expected bits and compares each one at a rising programming clock. A reversed bit order or a lost leading zero in a frame shows up as a wrong bit. A 101st or a missing clock shows up as a queue mismatch. The monitor measures the reset pulse width and flags a pulse that is stretched by a cycle. It checks that reset rises after the 32nd falling clock edge, so a design that releases reset on the rising edge or on a wrong count is caught. It also measures the settle gap and the exit hold against their minimum counts. Start and exit requests are injected mid-sequence and while ready, so a design that restarts or drops reset on them breaks the scoreboard order or the held-high reset check.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_PRELOW,
        S_PULSE,
        S_KEY,
        S_KEYEND,
        S_SETTLE,
        S_FRAME,
        S_READY,
        S_EXIT
    } pe_state_e;

    typedef struct packed {
        pe_state_e  st;
        logic [6:0] idx;
        logic       hi;
        logic       rst_n;
        logic       pclk;
        logic       pdat;
    } pe_regs_t;
endpackage

// File: rtl/pe_timer.sv
`timescale 1ns/1ps
module pe_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pe_bitsrc.sv
`timescale 1ns/1ps
module pe_bitsrc #(
    parameter logic [31:0] KEY_WORD   = 32'h8A12C2B2,
    parameter logic [31:0] SETUP_WORD = 32'h00801000,
    parameter int          LEAD_ZEROS = 2
) (
    input  logic       sel_key_i,
    input  logic [6:0] idx_i,
    output logic       bit_o
);
    localparam int FRAME_BITS = LEAD_ZEROS + 32;

    logic [6:0] pos;

    always_comb begin
        pos = (idx_i >= 7'(FRAME_BITS)) ? 7'(idx_i - 7'(FRAME_BITS)) : idx_i;
        if (sel_key_i)
            bit_o = KEY_WORD[idx_i[4:0]];
        else if (pos < 7'(LEAD_ZEROS))
            bit_o = 1'b0;
        else
            bit_o = SETUP_WORD[5'(pos - 7'(LEAD_ZEROS))];
    end
endmodule

// File: rtl/prog_entry_seq.sv
`timescale 1ns/1ps
module prog_entry_seq #(
    parameter int          CLK_HZ     = 50_000_000,
    parameter int          HALF_CYC   = 2,
    parameter logic [31:0] KEY_WORD   = 32'h8A12C2B2,
    parameter logic [31:0] SETUP_WORD = 32'h00801000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic exit_i,
    output logic tgt_rst_no,
    output logic pgm_clk_o,
    output logic pgm_dat_o,
    output logic busy_o,
    output logic ready_o
);
    import pe_pkg::*;

    localparam int LEAD_ZEROS  = 2;
    localparam int KEY_BITS    = 32;
    localparam int FRAME_BITS  = LEAD_ZEROS + 32;
    localparam int FRAMES      = 2;
    localparam int RST_LOW_CYC = CLK_HZ / 1000;
    localparam int SETTLE_CYC  = CLK_HZ / 2000;
    localparam int PULSE_RAW   = (CLK_HZ + 49_999_999) / 50_000_000;
    localparam int PULSE_CYC   = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
    localparam int PULSE_MAX   = (CLK_HZ / 500_000 < 1) ? 1 : CLK_HZ / 500_000;
    localparam int MAX_A       = (RST_LOW_CYC > SETTLE_CYC) ? RST_LOW_CYC : SETTLE_CYC;
    localparam int MAX_B       = (HALF_CYC > PULSE_CYC) ? HALF_CYC : PULSE_CYC;
    localparam int MAX_CNT     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W       = $clog2(MAX_CNT + 1);

    pe_regs_t r_d, r_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_zero;
    logic             src_key;
    logic [6:0]       src_idx;
    logic             src_bit;

    pe_timer #(.W(CNT_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (t_load),
        .load_val_i (t_val),
        .zero_o     (t_zero)
    );

    assign src_key = (r_q.st == S_PULSE) || (r_q.st == S_KEY);
    assign src_idx = ((r_q.st == S_PULSE) || (r_q.st == S_SETTLE)) ? 7'd0 : 7'(r_q.idx + 7'd1);

    pe_bitsrc #(
        .KEY_WORD   (KEY_WORD),
        .SETUP_WORD (SETUP_WORD),
        .LEAD_ZEROS (LEAD_ZEROS)
    ) u_bitsrc (
        .sel_key_i (src_key),
        .idx_i     (src_idx),
        .bit_o     (src_bit)
    );

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = '0;
        unique case (r_q.st)
            S_IDLE: begin
                r_d.rst_n = 1'b0;
                r_d.pclk  = 1'b0;
                r_d.pdat  = 1'b0;
                if (start_i) begin
                    r_d.st = S_PRELOW;
                    t_load = 1'b1;
                    t_val  = CNT_W'(RST_LOW_CYC - 1);
                end
            end
            S_PRELOW: if (t_zero) begin
                r_d.st    = S_PULSE;
                r_d.rst_n = 1'b1;
                t_load    = 1'b1;
                t_val     = CNT_W'(PULSE_CYC - 1);
            end
            S_PULSE: if (t_zero) begin
                r_d.st    = S_KEY;
                r_d.rst_n = 1'b0;
                r_d.idx   = 7'd0;
                r_d.hi    = 1'b0;
                r_d.pdat  = src_bit;
                t_load    = 1'b1;
                t_val     = CNT_W'(HALF_CYC - 1);
            end
            S_KEY, S_FRAME: if (t_zero) begin
                t_load = 1'b1;
                t_val  = CNT_W'(HALF_CYC - 1);
                if (!r_q.hi) begin
                    r_d.hi   = 1'b1;
                    r_d.pclk = 1'b1;
                end else begin
                    r_d.hi   = 1'b0;
                    r_d.pclk = 1'b0;
                    if (r_q.st == S_KEY && r_q.idx == 7'(KEY_BITS - 1)) begin
                        r_d.st   = S_KEYEND;
                        r_d.pdat = 1'b0;
                    end else if (r_q.st == S_FRAME &&
                                 r_q.idx == 7'(FRAMES * FRAME_BITS - 1)) begin
                        r_d.st   = S_READY;
                        r_d.pdat = 1'b0;
                        t_load   = 1'b0;
                    end else begin
                        r_d.idx  = src_idx;
                        r_d.pdat = src_bit;
                    end
                end
            end
            S_KEYEND: if (t_zero) begin
                r_d.st    = S_SETTLE;
                r_d.rst_n = 1'b1;
                t_load    = 1'b1;
                t_val     = CNT_W'(SETTLE_CYC - 1);
            end
            S_SETTLE: if (t_zero) begin
                r_d.st   = S_FRAME;
                r_d.idx  = 7'd0;
                r_d.hi   = 1'b0;
                r_d.pdat = src_bit;
                t_load   = 1'b1;
                t_val    = CNT_W'(HALF_CYC - 1);
            end
            S_READY: if (exit_i) begin
                r_d.st    = S_EXIT;
                r_d.rst_n = 1'b0;
                r_d.pclk  = 1'b0;
                r_d.pdat  = 1'b0;
                t_load    = 1'b1;
                t_val     = CNT_W'(RST_LOW_CYC - 1);
            end
            S_EXIT: if (t_zero) r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: S_IDLE, idx: 7'd0, hi: 1'b0, rst_n: 1'b0, pclk: 1'b0, pdat: 1'b0};
        else         r_q <= r_d;
    end

    assign tgt_rst_no = r_q.rst_n;
    assign pgm_clk_o  = r_q.pclk;
    assign pgm_dat_o  = r_q.pdat;
    assign busy_o     = (r_q.st != S_IDLE) && (r_q.st != S_READY);
    assign ready_o    = (r_q.st == S_READY);

    // Checker state: length of the current reset pulse.
    logic [15:0] pulse_run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           pulse_run_q <= '0;
        else if (r_q.st == S_PULSE && r_q.rst_n) pulse_run_q <= pulse_run_q + 16'd1;
        else                                   pulse_run_q <= '0;
    end

    p_pulse_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_run_q <= 16'(PULSE_MAX));
    p_dat_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pgm_clk_o && $past(pgm_clk_o)) |-> $stable(pgm_dat_o));
    p_rst_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(tgt_rst_no) && r_q.st == S_SETTLE) |-> !pgm_clk_o);
    p_settle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == S_SETTLE) |-> (!pgm_clk_o && tgt_rst_no));
    p_ready_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> (tgt_rst_no && !pgm_clk_o && !busy_o));
    p_start_ign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && start_i && !exit_i) |=> ready_o);
    p_exit_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && exit_i) |=> (busy_o && !tgt_rst_no && !pgm_clk_o));
    p_exit_ign_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == S_FRAME && exit_i) |=> tgt_rst_no);
endmodule

// File: tb/prog_entry_seq_tb_top.sv
`timescale 1ns/1ps
module prog_entry_seq_tb_top;
    localparam int          TB_HZ     = 1_000_000;
    localparam int          HALF      = 2;
    localparam int          RST_LOW   = TB_HZ / 1000;
    localparam int          SETTLE    = TB_HZ / 2000;
    localparam int          PULSE_EXP = (TB_HZ + 49_999_999) / 50_000_000;
    localparam logic [31:0] KEY       = 32'h8A12C2B2;
    localparam logic [31:0] SETUP     = 32'h00801000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ex = 1'b0;
    logic tgt_rst_no, pgm_clk_o, pgm_dat_o, busy_o, ready_o;

    prog_entry_seq #(.CLK_HZ(TB_HZ), .HALF_CYC(HALF)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .exit_i(ex),
        .tgt_rst_no(tgt_rst_no), .pgm_clk_o(pgm_clk_o), .pgm_dat_o(pgm_dat_o),
        .busy_o(busy_o), .ready_o(ready_o)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard and timing monitor
    bit exp_q[$];
    bit mon_on = 0, pulse_done = 0, in_gap = 0, lo_bad = 0;
    bit prev_clk = 0, prev_rst = 0, prev_dat = 0;
    int rise_cnt = 0, hi_run = 0, lo_run = 0, gap_run = 0, since_fall = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (in_gap) gap_run++;
            if (pgm_clk_o && !prev_clk) begin
                rise_cnt++;
                if (in_gap) begin
                    chk(gap_run - 1 >= SETTLE, "R6 settle gap", gap_run - 1, SETTLE);
                    in_gap = 0;
                end
                if (exp_q.size() == 0) begin
                    chk(0, "R7 extra clock", rise_cnt, 100);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(pgm_dat_o == e, (rise_cnt <= 32) ? "R4 key bit" : "R7 frame bit",
                        int'(pgm_dat_o), int'(e));
                end
            end
            if (pgm_clk_o && prev_clk)
                chk(pgm_dat_o == prev_dat, "R4 data moved while clock high",
                    int'(pgm_dat_o), int'(prev_dat));
            if (!pgm_clk_o && prev_clk) since_fall = 0;
            else                        since_fall++;
            if (!pulse_done && busy_o && !tgt_rst_no) begin
                lo_run++;
                if (pgm_clk_o || pgm_dat_o) lo_bad = 1;
            end
            if (!pulse_done && tgt_rst_no) hi_run++;
            if (tgt_rst_no && !prev_rst) begin
                if (!pulse_done) begin
                    chk(lo_run >= RST_LOW, "R2 pre-pulse low time", lo_run, RST_LOW);
                    chk(!lo_bad, "R2 clock/data low before pulse", int'(lo_bad), 0);
                end else begin
                    chk(rise_cnt == 32 && !pgm_clk_o && since_fall >= 1,
                        "R5 reset release point", rise_cnt, 32);
                    in_gap  = 1;
                    gap_run = 1;
                end
            end
            if (!tgt_rst_no && prev_rst && !pulse_done) begin
                chk(hi_run == PULSE_EXP, "R3 pulse width", hi_run, PULSE_EXP);
                pulse_done = 1;
            end
        end
        prev_clk = pgm_clk_o;
        prev_rst = tgt_rst_no;
        prev_dat = pgm_dat_o;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_entry(input bit disturb);
        exp_q.delete();
        for (int i = 0; i < 32; i++) exp_q.push_back(KEY[i]);
        for (int f = 0; f < 2; f++) begin
            exp_q.push_back(1'b0);
            exp_q.push_back(1'b0);
            for (int i = 0; i < 32; i++) exp_q.push_back(SETUP[i]);
        end
        rise_cnt = 0; hi_run = 0; lo_run = 0; gap_run = 0;
        pulse_done = 0; in_gap = 0; lo_bad = 0;
        mon_on = 1;
        start = 1'b1;
        tick(1);
        start = 1'b0;
        if (disturb) begin
            for (int k = 0; k < 20000 && rise_cnt < 40; k++) tick(1);
            start = 1'b1;
            ex    = 1'b1;
            tick(1);
            start = 1'b0;
            ex    = 1'b0;
            chk(busy_o, "R9 start during sequence", int'(busy_o), 1);
            chk(tgt_rst_no, "R11 exit during sequence", int'(tgt_rst_no), 1);
            tick(3);
            chk(tgt_rst_no && busy_o, "R11 reset still high", int'(tgt_rst_no), 1);
        end
        for (int k = 0; k < 20000 && !ready_o; k++) tick(1);
        tick(1);
        chk(rise_cnt == 100, "R7 clock count", rise_cnt, 100);
        chk(exp_q.size() == 0, "R7 bits left", exp_q.size(), 0);
        chk(ready_o && !busy_o, "R8 ready flags", {30'd0, ready_o, busy_o}, 2);
        chk(tgt_rst_no && !pgm_clk_o, "R8 reset held", int'(tgt_rst_no), 1);
    endtask

    task automatic run_exit();
        int run;
        mon_on = 0;
        ex = 1'b1;
        tick(1);
        ex = 1'b0;
        chk(!tgt_rst_no && !pgm_clk_o && !pgm_dat_o, "R10 pins dropped",
            int'(tgt_rst_no), 0);
        run = 0;
        for (int k = 0; k < 20000 && busy_o; k++) begin
            if (tgt_rst_no) run = -100000;
            run++;
            tick(1);
        end
        chk(run >= RST_LOW, "R10 exit hold", run, RST_LOW);
        chk(!busy_o && !ready_o && !tgt_rst_no, "R10 back to idle",
            {30'd0, busy_o, ready_o}, 0);
    endtask

    initial begin
        tick(3);
        chk(!tgt_rst_no && !pgm_clk_o && !pgm_dat_o, "R1 pins in reset",
            {29'd0, tgt_rst_no, pgm_clk_o, pgm_dat_o}, 0);
        rst_n = 1'b1;
        tick(3);
        chk(!busy_o && !ready_o && !tgt_rst_no, "R1 idle flags",
            {30'd0, busy_o, ready_o}, 0);

        run_entry(1'b1);

        start = 1'b1;
        tick(1);
        start = 1'b0;
        tick(20);
        chk(ready_o && rise_cnt == 100, "R9 start while ready", rise_cnt, 100);
        chk(tgt_rst_no, "R9 reset unchanged", int'(tgt_rst_no), 1);

        run_exit();
        tick(5);
        chk(!tgt_rst_no && !pgm_clk_o && !pgm_dat_o, "R1 idle pins after exit",
            {29'd0, tgt_rst_no, pgm_clk_o, pgm_dat_o}, 0);

        run_entry(1'b0);
        run_exit();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog all actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule